// File: doc/BRIEF.md
# Inter-Bank Block Copy Engine

This block copies a run of bytes from one 64KB bank of a 24-bit address space to another, one byte at a time, in ascending address order. A single start strobe hands it a source bank, a destination bank, a 16-bit source offset, a 16-bit destination offset and a 16-bit byte count. For each byte it reads the source location and then writes that byte to the destination location, using a simple request/ready memory port.

The offset and count values are working registers. They advance in place during the copy and stay visible on the outputs afterwards, so the caller can read where the copy stopped. Offsets wrap inside their 16 bits and never carry into the bank byte. When the copy ends, the destination bank is placed in a data-bank output register. A count of zero finishes without any memory traffic.

Top module: `blk_copy_engine`

## Requirements
- R1: After reset, busy, done and memReq are 0, and srcOff, dstOff, count and dataBank are all 0.
- R2: A start pulse seen while the engine is idle (busy=0, done=0) loads srcOff, dstOff and count from their inputs on that edge. For a nonzero count, busy is 1 in the following cycle.
- R3: Each byte is one read of address {srcBank, srcOff} (memWe=0) followed by one write of address {dstBank, dstOff} (memWe=1) that carries the byte returned by the read. memReq, memWe and memAddr hold steady until memReady is seen high at a clock edge.
- R4: After each accepted write, srcOff and dstOff each increase by 1 modulo 2^16. The bank bits of memAddr are unaffected, so offset 0xFFFF is followed by 0x0000 in the same bank.
- R5: count decreases by 1 per accepted write. At completion, count is 0 and each offset equals its start value plus the byte count, modulo 2^16.
- R6: done is high for exactly one cycle, in the cycle after the edge where the last write is accepted. busy is 0 in that cycle.
- R7: A start with count 0 gives done in the next cycle and makes no memory request.
- R8: dataBank keeps its previous value during a copy. It takes the destination bank when done rises, including for a zero-count start.
- R9: A start pulse while busy or done is high is ignored. The copy in progress keeps its addresses, data and final values.
- R10: Within a copy, byte k (counting from 0) is read at srcOff+k and written at dstOff+k, strictly in ascending k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start strobe |
| srcBankIn | input | 8 | Source bank |
| dstBankIn | input | 8 | Destination bank |
| srcOffIn | input | 16 | Source start offset |
| dstOffIn | input | 16 | Destination start offset |
| countIn | input | 16 | Number of bytes |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | 24 | Bank and offset of the access |
| memWdata | output | 8 | Write byte |
| memRdata | input | 8 | Read byte, valid while memReady is high |
| memReady | input | 1 | Access completes at this edge |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse |
| srcOff | output | 16 | Current or final source offset |
| dstOff | output | 16 | Current or final destination offset |
| count | output | 16 | Remaining byte count |
| dataBank | output | 8 | Destination bank of the last finished copy |

## Verification
The address-hold and one-read-then-one-write properties assume that the memory side raises memReady only while memReq is high. They also assume memRdata is valid in the same cycle as memReady. The bench's memory model changes memReady and memRdata only on the falling clock edge, and only in response to a pending request. Its pseudo-random stalls therefore never break these assumptions.

The zero-count property assumes start is judged against busy and done as the caller sees them. Every new start in the bench is issued only after done has come and gone, except the start pulse that is deliberately sent into a running copy.

// File: rtl/bme_pkg.sv
package bme_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_DONE  = 2'd3
  } bmeState_t;

  // strobes the sequencer sends to the datapath
  typedef struct packed {
    logic load;        // take offsets, count and banks from inputs
    logic capture;     // keep the byte returned by the read
    logic advance;     // step offsets and count after a write
    logic commitBank;  // copy destination bank to dataBank
    logic useDst;      // address mux: destination side
  } bmeStrobe_t;
endpackage

// File: rtl/bme_ctrl.sv
module bme_ctrl
  import bme_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       countInZero,
  input  logic       countLast,
  input  logic       memReady,
  output bmeStrobe_t strobe,
  output logic       memReq,
  output logic       memWe,
  output logic       busy,
  output logic       done
);
  bmeState_t state, stateNxt;

  always_comb begin
    stateNxt = state;
    strobe   = '0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.load = 1'b1;
          if (countInZero) begin
            strobe.commitBank = 1'b1;
            stateNxt = ST_DONE;
          end else begin
            stateNxt = ST_READ;
          end
        end
      end
      ST_READ: begin
        if (memReady) begin
          strobe.capture = 1'b1;
          stateNxt = ST_WRITE;
        end
      end
      ST_WRITE: begin
        strobe.useDst = 1'b1;
        if (memReady) begin
          strobe.advance = 1'b1;
          if (countLast) begin
            strobe.commitBank = 1'b1;
            stateNxt = ST_DONE;
          end else begin
            stateNxt = ST_READ;
          end
        end
      end
      ST_DONE: stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  assign memReq = (state == ST_READ) || (state == ST_WRITE);
  assign memWe  = (state == ST_WRITE);
  assign busy   = memReq;
  assign done   = (state == ST_DONE);

  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_not_busy_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(done && busy));

  p_req_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && $stable(memWe)));

  p_read_then_write_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memWe && memReady) |=> (memReq && memWe));
endmodule

// File: rtl/bme_dpath.sv
module bme_dpath
  import bme_pkg::*;
#(
  parameter int BANK_W = 8,
  parameter int OFF_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  bmeStrobe_t                strobe,
  input  logic [BANK_W-1:0]         srcBankIn,
  input  logic [BANK_W-1:0]         dstBankIn,
  input  logic [OFF_W-1:0]          srcOffIn,
  input  logic [OFF_W-1:0]          dstOffIn,
  input  logic [OFF_W-1:0]          countIn,
  input  logic [DATA_W-1:0]         memRdata,
  output logic [BANK_W+OFF_W-1:0]   memAddr,
  output logic [DATA_W-1:0]         memWdata,
  output logic                      countInZero,
  output logic                      countLast,
  output logic [OFF_W-1:0]          srcOff,
  output logic [OFF_W-1:0]          dstOff,
  output logic [OFF_W-1:0]          count,
  output logic [BANK_W-1:0]         dataBank
);
  localparam logic [OFF_W-1:0] OFF_ONE  = {{(OFF_W-1){1'b0}}, 1'b1};
  localparam logic [OFF_W-1:0] OFF_ZERO = '0;

  logic [BANK_W-1:0] srcBank, dstBank;
  logic [DATA_W-1:0] byteHold;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcBank <= '0;
      dstBank <= '0;
      srcOff  <= '0;
      dstOff  <= '0;
      count   <= '0;
    end else if (strobe.load) begin
      srcBank <= srcBankIn;
      dstBank <= dstBankIn;
      srcOff  <= srcOffIn;
      dstOff  <= dstOffIn;
      count   <= countIn;
    end else if (strobe.advance) begin
      srcOff  <= srcOff + OFF_ONE;   // wraps inside OFF_W bits
      dstOff  <= dstOff + OFF_ONE;
      count   <= count - OFF_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               byteHold <= '0;
    else if (strobe.capture) byteHold <= memRdata;
  end

  // for zero count, the bank comes straight from the input on the load edge
  always_ff @(posedge clk) begin
    if (!rstN) dataBank <= '0;
    else if (strobe.commitBank) dataBank <= strobe.load ? dstBankIn : dstBank;
  end

  assign memAddr     = strobe.useDst ? {dstBank, dstOff} : {srcBank, srcOff};
  assign memWdata    = byteHold;
  assign countInZero = (countIn == OFF_ZERO);
  assign countLast   = (count == OFF_ONE);

  p_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> (srcOff == $past(srcOff) + OFF_ONE) && (dstOff == $past(dstOff) + OFF_ONE));

  p_count_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advance |=> (count == $past(count) - OFF_ONE));

  p_bank_still_r8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commitBank |=> $stable(dataBank));
endmodule

// File: rtl/blk_copy_engine.sv
module blk_copy_engine
  import bme_pkg::*;
#(
  parameter int BANK_W = 8,
  parameter int OFF_W  = 16,
  parameter int DATA_W = 8,
  localparam int ADDR_W = BANK_W + OFF_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [BANK_W-1:0] srcBankIn,
  input  logic [BANK_W-1:0] dstBankIn,
  input  logic [OFF_W-1:0]  srcOffIn,
  input  logic [OFF_W-1:0]  dstOffIn,
  input  logic [OFF_W-1:0]  countIn,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memReady,
  output logic              busy,
  output logic              done,
  output logic [OFF_W-1:0]  srcOff,
  output logic [OFF_W-1:0]  dstOff,
  output logic [OFF_W-1:0]  count,
  output logic [BANK_W-1:0] dataBank
);
  bmeStrobe_t strobe;
  logic countInZero, countLast;

  bme_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .countInZero(countInZero), .countLast(countLast), .memReady(memReady),
    .strobe(strobe), .memReq(memReq), .memWe(memWe), .busy(busy), .done(done)
  );

  bme_dpath #(.BANK_W(BANK_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .srcBankIn(srcBankIn), .dstBankIn(dstBankIn),
    .srcOffIn(srcOffIn), .dstOffIn(dstOffIn), .countIn(countIn),
    .memRdata(memRdata), .memAddr(memAddr), .memWdata(memWdata),
    .countInZero(countInZero), .countLast(countLast),
    .srcOff(srcOff), .dstOff(dstOff), .count(count), .dataBank(dataBank)
  );

  p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> $stable(memAddr));

  p_zero_quick_r7: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && !done && countIn == '0) |=> (done && !memReq));

  p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !(memWe && memReady)) |=> ($stable(srcOff) && $stable(count)));
endmodule

// File: tb/tb_blk_copy_engine.sv
module tb_blk_copy_engine;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [7:0]  srcBankIn = '0, dstBankIn = '0;
  logic [15:0] srcOffIn = '0, dstOffIn = '0, countIn = '0;
  logic memReq, memWe, busy, done;
  logic [23:0] memAddr;
  logic [7:0]  memWdata, dataBank;
  logic [7:0]  memRdata = '0;
  logic memReady = 1'b0;
  logic [15:0] srcOff, dstOff, count;

  int nChecks = 0;
  int nFails  = 0;
  int cyc     = 0;
  bit finished = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic [23:0] expRd[$];
  logic [31:0] expWr[$];

  always #10 clk = ~clk;  // 50 MHz

  blk_copy_engine dut (
    .clk(clk), .rstN(rstN), .start(start),
    .srcBankIn(srcBankIn), .dstBankIn(dstBankIn),
    .srcOffIn(srcOffIn), .dstOffIn(dstOffIn), .countIn(countIn),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memReady(memReady),
    .busy(busy), .done(done), .srcOff(srcOff), .dstOff(dstOff),
    .count(count), .dataBank(dataBank)
  );

  function automatic logic [7:0] pat(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  // memory model and monitor: act away from the rising edge
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    memReady = memReq && (lfsr[1:0] != 2'b00);
    memRdata = pat(memAddr);
    if (memReq && memReady) begin
      if (!memWe) begin
        if (expRd.size() == 0) chk("R3 unexpected read", {8'h0, memAddr}, 32'hFFFFFFFF);
        else chk("R10 read address", {8'h0, memAddr}, {8'h0, expRd.pop_front()});
      end else begin
        if (expWr.size() == 0) chk("R3 unexpected write", {memAddr, memWdata}, 32'hFFFFFFFF);
        else chk("R3 write address/data", {memAddr, memWdata}, expWr.pop_front());
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc >= 20000 && !finished) begin
      nFails++;
      $display("FAIL watchdog: actual cycle %0d expected under 20000", cyc);
      summary();
    end
  end

  task automatic run_move(input logic [7:0] sb, input logic [7:0] db,
                          input logic [15:0] so, input logic [15:0] dof,
                          input logic [15:0] n, input bit poke);
    logic [7:0] prevBank = dataBank;
    for (int k = 0; k < int'(n); k++) begin
      logic [23:0] ra = {sb, so + 16'(k)};
      expRd.push_back(ra);
      expWr.push_back({db, dof + 16'(k), pat(ra)});
    end
    @(negedge clk);
    srcBankIn = sb; dstBankIn = db; srcOffIn = so; dstOffIn = dof; countIn = n;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (n == 16'd0) begin
      chk("R7 done next cycle", {31'b0, done}, 32'd1);
      chk("R7 no request", {31'b0, memReq}, 32'd0);
    end else begin
      chk("R2 busy after start", {31'b0, busy}, 32'd1);
      chk("R2 count loaded", {16'b0, count}, {16'b0, n});
      chk("R8 bank held during copy", {24'b0, dataBank}, {24'b0, prevBank});
      if (poke) begin
        @(negedge clk);
        srcBankIn = 8'hEE; dstBankIn = 8'hDD; srcOffIn = 16'h1111;
        dstOffIn = 16'h2222; countIn = 16'h0003; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
      while (!done) @(negedge clk);
      chk("R6 busy low with done", {31'b0, busy}, 32'd0);
    end
    chk("R6 all bytes moved before done", expWr.size(), 32'd0);
    chk("R5 final srcOff", {16'b0, srcOff}, {16'b0, so + n});
    chk("R5 final dstOff", {16'b0, dstOff}, {16'b0, dof + n});
    chk("R5 final count", {16'b0, count}, 32'd0);
    chk("R8 dataBank", {24'b0, dataBank}, {24'b0, db});
    @(negedge clk);
    chk("R6 done single cycle", {31'b0, done}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", {31'b0, busy}, 32'd0);
    chk("R1 done", {31'b0, done}, 32'd0);
    chk("R1 memReq", {31'b0, memReq}, 32'd0);
    chk("R1 offsets", {srcOff, dstOff}, 32'd0);
    chk("R1 count/bank", {8'b0, count, dataBank}, 32'd0);
    run_move(8'h01, 8'h02, 16'h2000, 16'h4000, 16'd5, 1'b0);  // R3 R10
    run_move(8'h10, 8'h20, 16'hFFFE, 16'hFFFD, 16'd6, 1'b0);  // R4 wrap
    run_move(8'h05, 8'h33, 16'h0100, 16'h0200, 16'd0, 1'b0);  // R7 zero count
    run_move(8'h40, 8'h41, 16'h8000, 16'h9000, 16'd8, 1'b1);  // R9 start ignored
    run_move(8'h7F, 8'h80, 16'hFFFF, 16'h0000, 16'd1, 1'b0);  // single byte
    repeat (3) @(negedge clk);
    chk("R9 no stray access", expRd.size() + expWr.size(), 32'd0);
    summary();
  end
endmodule